// File: doc/BRIEF.md
# Reed-Solomon codeword error checker

This block estimates the codeword error ratio of a Reed-Solomon protected link without decoding. It receives two streams of FEC symbols in lockstep: the symbols that were sent and the symbols that arrived after the channel. It compares them one symbol at a time and counts the mismatches in each codeword. It then compares that count with the code's correction limit. A codeword whose count exceeds the limit would not have been corrected by a real decoder, so the block marks it as failed. A mismatch counter and a threshold test take far less logic than a decoder, so many link emulations can run side by side on one device.

The block is a two-state machine. `ST_IDLE` means no codeword is open. `ST_COLLECT` means a codeword is being gathered.
- `ST_IDLE` to `ST_COLLECT`: a valid symbol arrives with the start marker.
- `ST_COLLECT` to `ST_COLLECT`: any further valid symbol. If that symbol carries the start marker, the partial codeword is discarded and a new one starts with it.
- `ST_COLLECT` to `ST_IDLE`: the last symbol of the codeword is accepted.

When a codeword completes, a one-cycle pulse presents its mismatch count and its pass/fail verdict. Three wide, saturating totals count codewords checked, codewords failed and symbols in error. They can be read at any time and cleared together.

Top module: `rs_cw_err_chk`

## Requirements
- R1: After reset, `cw_done`, `cw_fail`, `cw_errs`, `frame_err` and all three totals are zero.
- R2: A symbol is errored when any bit of `tx_sym` differs from `rx_sym`. It is counted once, however many of its bits differ, and `cw_errs` equals the number of errored symbols in the codeword.
- R3: A codeword opens only on a cycle with both `in_valid` and `in_sof` high. Valid symbols without `in_sof` while no codeword is open have no effect on any output.
- R4: `cw_done` is high for exactly one cycle, in the cycle after the clock edge that accepts the CW_LEN-th valid symbol. `cw_errs` and `cw_fail` are updated at that edge and hold until the next completion.
- R5: `cw_fail` is high with `cw_done` exactly when the mismatch count is greater than T_CORR. A count of exactly T_CORR passes.
- R6: Cycles with `in_valid` low neither advance the symbol position nor add to the count, whatever the data inputs carry.
- R7: If `in_sof` arrives with `in_valid` while a codeword is open, the partial codeword is dropped and not counted in any total, `frame_err` is set and stays set, and a new codeword starts with that symbol.
- R8: Each completion adds one to `tot_cw`. Each failed completion adds one to `tot_fail`. Each completion adds `cw_errs` to `tot_sym_err`.
- R9: Each total stops at 2^TOT_W-1 instead of wrapping.
- R10: `clr_totals` synchronously zeroes the three totals and `frame_err`, and it wins over an increment or a framing error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr_totals | input | 1 | Synchronous clear of the totals and the framing flag |
| in_valid | input | 1 | Symbol pair valid this cycle |
| in_sof | input | 1 | First symbol of a codeword |
| tx_sym | input | SYM_W | Transmitted reference symbol |
| rx_sym | input | SYM_W | Received symbol |
| cw_done | output | 1 | One-cycle codeword completion pulse |
| cw_fail | output | 1 | Last completed codeword exceeded the correction limit |
| cw_errs | output | clog2(CW_LEN+1) | Errored symbols in the last completed codeword |
| frame_err | output | 1 | Sticky: a codeword was cut short by a start marker |
| tot_cw | output | TOT_W | Codewords completed |
| tot_fail | output | TOT_W | Codewords failed |
| tot_sym_err | output | TOT_W | Errored symbols in completed codewords |

## Verification
The hardest cases to reach from the ports are the saturation of the totals and a clear landing on the same edge as a completion. At the default widths, saturation would take longer than any run. The bench therefore builds the block with a short codeword, a small limit and 8-bit totals, then drives several hundred codewords with random error counts clustered around the limit, random idle gaps and occasional early start markers. One directed codeword places the clear pulse on its final symbol. Further directed codewords cover a count exactly at the limit and one above it, symbols with every bit flipped, and valid traffic while no codeword is open.

// File: rtl/rs_chk_pkg.sv
package rs_chk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } cw_state_t;

    localparam int NUM_TOT = 3;
    localparam int TOT_CW   = 0;
    localparam int TOT_FAIL = 1;
    localparam int TOT_SYM  = 2;
endpackage

// File: rtl/rs_sym_cmp.sv
module rs_sym_cmp #(
    parameter int SYM_W = 10
) (
    input  logic [SYM_W-1:0] ref_sym,
    input  logic [SYM_W-1:0] got_sym,
    output logic             sym_bad
);
    // whole-symbol compare: any differing bit marks the symbol once
    assign sym_bad = |(ref_sym ^ got_sym);
endmodule

// File: rtl/rs_sat_acc.sv
module rs_sat_acc #(
    parameter int W  = 48,
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  acc
);
    logic [W:0] sum;

    assign sum = {1'b0, acc} + {{(W+1-IW){1'b0}}, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum[W] ? {W{1'b1}} : sum[W-1:0];
        end
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> acc >= $past(acc)); // R9
    AST_ACC_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (&acc)) |=> (&acc)); // R9
endmodule

// File: rtl/rs_cw_err_chk.sv
module rs_cw_err_chk
    import rs_chk_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int CW_LEN = 544,
    parameter int T_CORR = 15,
    parameter int TOT_W  = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_totals,
    input  logic                          in_valid,
    input  logic                          in_sof,
    input  logic [SYM_W-1:0]              tx_sym,
    input  logic [SYM_W-1:0]              rx_sym,
    output logic                          cw_done,
    output logic                          cw_fail,
    output logic [$clog2(CW_LEN+1)-1:0]   cw_errs,
    output logic                          frame_err,
    output logic [TOT_W-1:0]              tot_cw,
    output logic [TOT_W-1:0]              tot_fail,
    output logic [TOT_W-1:0]              tot_sym_err
);
    localparam int IDX_W = $clog2(CW_LEN + 1);
    localparam int MC_W  = IDX_W;
    localparam logic [MC_W-1:0]  MC_MAX   = {MC_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CW_LEN);
    localparam logic [MC_W-1:0]  LIMIT    = MC_W'(T_CORR);

    cw_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_base, idx_new;
    logic [MC_W-1:0]  mism_q, cnt_base, cnt_new;
    logic             sym_bad, first, cont, take, last, fail_now;

    rs_sym_cmp #(.SYM_W(SYM_W)) u_cmp (
        .ref_sym (tx_sym),
        .got_sym (rx_sym),
        .sym_bad (sym_bad)
    );

    // symbol acceptance and running count
    always_comb begin
        first    = in_valid && in_sof;
        cont     = in_valid && !in_sof && (state_q == ST_COLLECT);
        take     = first || cont;
        idx_base = first ? '0 : idx_q;
        cnt_base = first ? '0 : mism_q;
        idx_new  = idx_base + IDX_W'(1);
        cnt_new  = (sym_bad && (cnt_base != MC_MAX)) ? cnt_base + MC_W'(1) : cnt_base;
        last     = take && (idx_new == LAST_IDX);
        fail_now = cnt_new > LIMIT;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first) state_d = last ? ST_IDLE : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and per-codeword outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            mism_q    <= '0;
            cw_done   <= 1'b0;
            cw_fail   <= 1'b0;
            cw_errs   <= '0;
            frame_err <= 1'b0;
        end else begin
            cw_done <= last;
            if (last) begin
                cw_errs <= cnt_new;
                cw_fail <= fail_now;
            end
            if (take) begin
                idx_q  <= last ? '0 : idx_new;
                mism_q <= last ? '0 : cnt_new;
            end
            if (clr_totals)
                frame_err <= 1'b0;
            else if (first && (state_q == ST_COLLECT))
                frame_err <= 1'b1;
        end
    end

    // running totals
    logic            acc_en  [NUM_TOT];
    logic [MC_W-1:0] acc_inc [NUM_TOT];
    logic [TOT_W-1:0] acc_val [NUM_TOT];

    always_comb begin
        acc_en[TOT_CW]    = last;
        acc_inc[TOT_CW]   = MC_W'(1);
        acc_en[TOT_FAIL]  = last && fail_now;
        acc_inc[TOT_FAIL] = MC_W'(1);
        acc_en[TOT_SYM]   = last;
        acc_inc[TOT_SYM]  = cnt_new;
    end

    for (genvar g = 0; g < NUM_TOT; g++) begin : g_tot
        rs_sat_acc #(.W(TOT_W), .IW(MC_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_totals),
            .en    (acc_en[g]),
            .inc   (acc_inc[g]),
            .acc   (acc_val[g])
        );
    end

    assign tot_cw      = acc_val[TOT_CW];
    assign tot_fail    = acc_val[TOT_FAIL];
    assign tot_sym_err = acc_val[TOT_SYM];

    if (CW_LEN > 1) begin : g_pulse_chk
        AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            cw_done |=> !cw_done); // R4
    end
    AST_FAIL_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        cw_done |-> (cw_fail == (cw_errs > LIMIT))); // R5
    AST_ERRS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cw_done |-> (cw_errs <= MC_W'(CW_LEN))); // R2
    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !clr_totals) |=> frame_err); // R7
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && !in_sof) |=> (idx_q == '0 && !cw_done)); // R3
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(idx_q) && $stable(mism_q))); // R6
    AST_FAIL_TOTAL_LE: assert property (@(posedge clk) disable iff (!rst_n)
        tot_fail <= tot_cw); // R8
endmodule

// File: tb/sim_rs_cw_err_chk.sv
module sim_rs_cw_err_chk;
    localparam int SW = 10;
    localparam int CW = 20;
    localparam int TC = 3;
    localparam int TW = 8;
    localparam int MW = $clog2(CW + 1);
    localparam longint TMAX = (longint'(1) << TW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, v = 1'b0, s = 1'b0;
    logic [SW-1:0] tx = '0, rx = '0;
    logic cw_done, cw_fail, frame_err;
    logic [MW-1:0] cw_errs;
    logic [TW-1:0] tot_cw, tot_fail, tot_sym_err;

    rs_cw_err_chk #(.SYM_W(SW), .CW_LEN(CW), .T_CORR(TC), .TOT_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_totals(clr), .in_valid(v), .in_sof(s),
        .tx_sym(tx), .rx_sym(rx), .cw_done(cw_done), .cw_fail(cw_fail),
        .cw_errs(cw_errs), .frame_err(frame_err), .tot_cw(tot_cw),
        .tot_fail(tot_fail), .tot_sym_err(tot_sym_err)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;
    int m_idx = 0, m_cnt = 0;
    bit m_act = 0, m_ferr = 0;
    longint t_cw = 0, t_fail = 0, t_sym = 0;
    int e_errs = 0;
    bit e_fail = 0, e_done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat_add(input longint a, input longint b);
        return (a + b > TMAX) ? TMAX : a + b;
    endfunction

    // one clock of stimulus, then compare every output with the model
    task automatic step(input bit iv, input bit is, input bit ic,
                        input logic [SW-1:0] itx, input logic [SW-1:0] irx);
        string ttag;
        v = iv; s = is; clr = ic; tx = itx; rx = irx;
        @(posedge clk);
        @(negedge clk);
        e_done = 0;
        if (iv && is) begin
            if (m_act) m_ferr = 1;
            m_act = 1; m_idx = 1; m_cnt = (itx != irx) ? 1 : 0;
        end else if (iv && m_act) begin
            m_idx++; m_cnt += (itx != irx) ? 1 : 0;
        end
        if (m_act && m_idx == CW) begin
            e_done = 1; m_act = 0; e_errs = m_cnt; e_fail = (m_cnt > TC);
            t_cw = sat_add(t_cw, 1);
            if (e_fail) t_fail = sat_add(t_fail, 1);
            t_sym = sat_add(t_sym, m_cnt);
        end
        if (ic) begin t_cw = 0; t_fail = 0; t_sym = 0; m_ferr = 0; end
        chk(cw_done == e_done, "R4 done pulse", cw_done, e_done);
        chk(cw_errs == e_errs, "R2 errored symbol count", cw_errs, e_errs);
        chk(cw_fail == e_fail, "R5 fail verdict", cw_fail, e_fail);
        chk(frame_err == m_ferr, ic ? "R10 frame clear" : "R7 framing flag", frame_err, m_ferr);
        ttag = ic ? "R10 totals clear" : ((t_cw == TMAX || t_sym == TMAX) ? "R9 saturation" : "R8 totals");
        chk(tot_cw == t_cw, ttag, tot_cw, t_cw);
        chk(tot_fail == t_fail, ttag, tot_fail, t_fail);
        chk(tot_sym_err == t_sym, ttag, tot_sym_err, t_sym);
    endtask

    // a codeword with nerr errored symbols at random positions
    task automatic send_cw(input int nerr, input bit multi, input int gap_pct,
                           input bit clr_last, input int stop_at);
        bit bad [CW];
        int placed = 0;
        for (int i = 0; i < CW; i++) bad[i] = 0;
        while (placed < nerr && placed < CW) begin
            int p = int'($urandom % CW);
            if (!bad[p]) begin bad[p] = 1; placed++; end
        end
        for (int i = 0; i < CW && i < stop_at; i++) begin
            logic [SW-1:0] a, b;
            while (int'($urandom % 100) < gap_pct)
                step(1'b0, 1'b1, 1'b0, SW'($urandom), SW'($urandom));  // R6 idle noise
            a = SW'($urandom);
            if (!bad[i]) b = a;
            else if (multi) b = ~a;
            else b = a ^ (SW'(1) << ($urandom % SW));
            step(1'b1, i == 0, clr_last && i == CW - 1, a, b);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cw_done == 0 && cw_fail == 0 && cw_errs == 0, "R1 reset outputs", cw_errs, 0);
        chk(frame_err == 0, "R1 reset frame flag", frame_err, 0);
        chk(tot_cw == 0 && tot_fail == 0 && tot_sym_err == 0, "R1 reset totals", tot_sym_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 valid traffic with no codeword open
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, SW'(i), ~SW'(i));
        send_cw(0, 0, 0, 0, CW);              // R4 clean codeword
        send_cw(TC, 0, 0, 0, CW);             // R5 exactly at the limit
        send_cw(TC + 1, 0, 0, 0, CW);         // R5 one above
        send_cw(CW, 1, 0, 0, CW);             // R2 every bit of every symbol
        send_cw(2, 0, 50, 0, CW);             // R6 gaps inside a codeword
        send_cw(4, 0, 0, 0, 7);               // R7 cut short
        send_cw(1, 0, 0, 0, CW);
        chk(frame_err == 1, "R7 sticky after restart", frame_err, 1);
        step(1'b0, 1'b0, 1'b1, '0, '0);       // R10 plain clear
        send_cw(5, 0, 0, 1, CW);              // R10 clear on the final symbol
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 10) == 0) send_cw(3, 0, 5, 0, 1 + int'($urandom % (CW - 1)));
            send_cw(int'($urandom % 8), bit'($urandom % 2), int'($urandom % 30), 0, CW);
        end
        chk(tot_cw == TMAX, "R9 codeword total held at top", tot_cw, TMAX);
        chk(tot_sym_err == TMAX, "R9 symbol total held at top", tot_sym_err, TMAX);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule